// File: doc/BRIEF.md
# Dual Timer Transmit Output Combiner

This block holds two down-counting timers, a short one and a long one. Each timer drives its own output, and that output flips level every time the timer wraps through zero. A selectable logic function merges the two timer outputs into one transmit output. Typical uses are carrier and envelope generation for an infrared or serial transmit line: one timer sets the carrier and the other gates it.

A mode field selects one of four behaviours:

- independent operation of both timers;
- alternating (ping-pong) operation, where the short timer always takes the first turn;
- long timer output held low;
- long timer output held high.

Each timer also has a start-level bit. The timer output takes that level on the clock edge where counting begins. While the timer is idle, its output rests at the opposite level, so enabling a timer always produces a visible edge.

Top module: `dtx_combiner`

## Requirements
- R1: While `rst` is high at a clock edge, both timer outputs are set to 1. `tx_out` then follows the combine function of those levels.
- R2: `tx_out` is a combinational function of `short_out` and `long_out`, chosen by `combine_sel`:
  - 2'b00 gives AND;
  - 2'b01 gives OR;
  - 2'b10 gives NOR;
  - 2'b11 gives NAND.
- R3: While a timer is not enabled, its output settles at the inverse of its latched start-level bit. This happens one edge after the timer is disabled, or two edges after a start-level change made while both timers are disabled.
- R4: On the first edge where a timer is enabled, its output takes the latched start-level value and its count loads the reload value.
- R5: In independent mode (`submode_sel` = 2'b00), a running timer reloads and flips its output every reload+1 cycles. The first flip comes reload+1 edges after the start edge.
- R6: In ping-pong mode (`submode_sel` = 2'b01), the timers count only while both enables are high.
  - The short timer runs first. At its terminal count it reloads, flips its output and stops.
  - The long timer then counts from its reload value, and the turns alternate.
  - A stopped timer keeps its output level.
- R7: Switching from ping-pong to independent mode ends the alternation. From the next edge, both enabled timers count at the same time from their current counts.
- R8: `submode_sel` = 2'b10 forces `long_out` to 0, and 2'b11 forces it to 1. Both take effect in the same cycle, whatever the state of `long_en` and `long_init`.
- R9: The start-level bits are latched only on edges where both enables are low. A change made while either timer is enabled has no effect until both are disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| short_en | input | 1 | Enable of the short timer |
| long_en | input | 1 | Enable of the long timer |
| short_reload | input | 8 | Reload value of the short timer |
| long_reload | input | 16 | Reload value of the long timer |
| combine_sel | input | 2 | Output merge function: 00 AND, 01 OR, 10 NOR, 11 NAND |
| submode_sel | input | 2 | 00 independent, 01 ping-pong, 10 long output low, 11 long output high |
| short_init | input | 1 | Start level of the short timer output |
| long_init | input | 1 | Start level of the long timer output |
| short_out | output | 1 | Short timer output |
| long_out | output | 1 | Long timer output |
| tx_out | output | 1 | Merged transmit output |

## Verification
The assertions assume the following about the inputs:
- The reload values stay constant while a timer is running.
- The mode field changes only between clock edges.
- Reset is held for at least one edge before any property is meaningful.

The stimulus respects all three. It programs reload values and start levels only while the timers are idle, and drives every input at the falling clock edge. The bench also changes a start-level bit while a timer runs, but only to show that the latch ignores it. The ping-pong check depends on the mode field staying stable throughout each sequence, which the stimulus also keeps.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

    typedef enum logic [1:0] {
        CMB_AND  = 2'b00,
        CMB_OR   = 2'b01,
        CMB_NOR  = 2'b10,
        CMB_NAND = 2'b11
    } combine_e;

    typedef enum logic [1:0] {
        SUB_NORMAL   = 2'b00,
        SUB_PINGPONG = 2'b01,
        SUB_FORCE0   = 2'b10,
        SUB_FORCE1   = 2'b11
    } submode_e;

    typedef enum logic {
        PH_SHORT = 1'b0,
        PH_LONG  = 1'b1
    } phase_e;

    typedef struct packed {
        logic enable;
        logic run;
    } tmr_ctl_t;

    function automatic logic merge_levels(input combine_e sel, input logic a, input logic b);
        logic r;
        case (sel)
            CMB_AND:  r = a & b;
            CMB_OR:   r = a | b;
            CMB_NOR:  r = ~(a | b);
            default:  r = ~(a & b);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dtx_down_timer.sv
module dtx_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         run,
    input  logic         init_lvl,
    input  logic [W-1:0] reload,
    output logic         out,
    output logic         tc
);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt;
    logic         started;

    assign tc = enable && started && run && (cnt == ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= ZERO;
            started <= 1'b0;
            out     <= 1'b1;
        end else if (!enable) begin
            started <= 1'b0;
            cnt     <= reload;
            out     <= ~init_lvl;
        end else if (!started) begin
            started <= 1'b1;
            cnt     <= reload;
            out     <= init_lvl;
        end else if (run) begin
            if (cnt == ZERO) begin
                cnt <= reload;
                out <= ~out;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (out == ~$past(init_lvl)));

    // R4
    start_level_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !started) |=> (out == $past(init_lvl)));

    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
        tc |=> ((cnt == $past(reload)) && (out != $past(out))));

    // R6
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && started && !run) |=> ($stable(out) && $stable(cnt)));

endmodule

// File: rtl/dtx_pingpong_seq.sv
module dtx_pingpong_seq
    import dtx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  submode_e submode,
    input  logic     short_en,
    input  logic     long_en,
    input  logic     short_tc,
    input  logic     long_tc,
    output tmr_ctl_t short_ctl,
    output tmr_ctl_t long_ctl
);
    phase_e phase;
    logic   pp_on;

    assign pp_on = (submode == SUB_PINGPONG) && short_en && long_en;

    always_ff @(posedge clk) begin
        if (rst || !pp_on) begin
            phase <= PH_SHORT;
        end else if (phase == PH_SHORT && short_tc) begin
            phase <= PH_LONG;
        end else if (phase == PH_LONG && long_tc) begin
            phase <= PH_SHORT;
        end
    end

    always_comb begin
        short_ctl = '{enable: short_en, run: 1'b1};
        long_ctl  = '{enable: long_en,  run: 1'b1};
        case (submode)
            SUB_PINGPONG: begin
                short_ctl = '{enable: short_en && long_en, run: phase == PH_SHORT};
                long_ctl  = '{enable: short_en && long_en, run: phase == PH_LONG};
            end
            SUB_FORCE0, SUB_FORCE1: begin
                long_ctl = '{enable: 1'b0, run: 1'b0};
            end
            default: ;
        endcase
    end

    // R6
    single_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        pp_on |-> !(short_tc && long_tc));

    // R6
    handoff_chk: assert property (@(posedge clk) disable iff (rst)
        (pp_on && short_tc && phase == PH_SHORT) |=> (phase == PH_LONG || !pp_on));

endmodule

// File: rtl/dtx_combiner.sv
module dtx_combiner
    import dtx_pkg::*;
#(
    parameter int SHORT_W = 8,
    parameter int LONG_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               short_en,
    input  logic               long_en,
    input  logic [SHORT_W-1:0] short_reload,
    input  logic [LONG_W-1:0]  long_reload,
    input  logic [1:0]         combine_sel,
    input  logic [1:0]         submode_sel,
    input  logic               short_init,
    input  logic               long_init,
    output logic               short_out,
    output logic               long_out,
    output logic               tx_out
);
    submode_e submode;
    combine_e cmb;
    tmr_ctl_t short_ctl, long_ctl;
    logic     short_tc, long_tc;
    logic     long_raw;
    logic     short_init_q, long_init_q;
    logic     both_idle;

    assign submode   = submode_e'(submode_sel);
    assign cmb       = combine_e'(combine_sel);
    assign both_idle = !short_en && !long_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            short_init_q <= 1'b0;
            long_init_q  <= 1'b0;
        end else if (both_idle) begin
            short_init_q <= short_init;
            long_init_q  <= long_init;
        end
    end

    dtx_pingpong_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .submode   (submode),
        .short_en  (short_en),
        .long_en   (long_en),
        .short_tc  (short_tc),
        .long_tc   (long_tc),
        .short_ctl (short_ctl),
        .long_ctl  (long_ctl)
    );

    dtx_down_timer #(.W(SHORT_W)) short_tmr_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (short_ctl.enable),
        .run      (short_ctl.run),
        .init_lvl (short_init_q),
        .reload   (short_reload),
        .out      (short_out),
        .tc       (short_tc)
    );

    dtx_down_timer #(.W(LONG_W)) long_tmr_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (long_ctl.enable),
        .run      (long_ctl.run),
        .init_lvl (long_init_q),
        .reload   (long_reload),
        .out      (long_raw),
        .tc       (long_tc)
    );

    always_comb begin
        case (submode)
            SUB_FORCE0: long_out = 1'b0;
            SUB_FORCE1: long_out = 1'b1;
            default:    long_out = long_raw;
        endcase
    end

    assign tx_out = merge_levels(cmb, short_out, long_out);

    // R9
    init_latch_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(both_idle) |-> ($stable(short_init_q) && $stable(long_init_q)));

    // R8
    force_level_chk: assert property (@(posedge clk) disable iff (rst)
        (submode_sel[1]) |-> (long_out == submode_sel[0]));

endmodule

// File: tb/dtx_combiner_tb_top.sv
module dtx_combiner_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        short_en, long_en;
    logic [7:0]  short_reload;
    logic [15:0] long_reload;
    logic [1:0]  combine_sel, submode_sel;
    logic        short_init, long_init;
    logic        short_out, long_out, tx_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dtx_combiner dut_i (
        .clk          (clk),
        .rst          (rst),
        .short_en     (short_en),
        .long_en      (long_en),
        .short_reload (short_reload),
        .long_reload  (long_reload),
        .combine_sel  (combine_sel),
        .submode_sel  (submode_sel),
        .short_init   (short_init),
        .long_init    (long_init),
        .short_out    (short_out),
        .long_out     (long_out),
        .tx_out       (tx_out)
    );

    // {combine_sel, short_init, long_init, expected tx_out}; idle outputs are inverted inits
    localparam logic [4:0] VEC [16] = '{
        5'b00_00_1, 5'b00_01_0, 5'b00_10_0, 5'b00_11_0,
        5'b01_00_1, 5'b01_01_1, 5'b01_10_1, 5'b01_11_0,
        5'b10_00_0, 5'b10_01_0, 5'b10_10_0, 5'b10_11_1,
        5'b11_00_0, 5'b11_01_1, 5'b11_10_1, 5'b11_11_1
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; short_en = 0; long_en = 0;
        short_reload = 8'd0; long_reload = 16'd0;
        combine_sel = 2'b00; submode_sel = 2'b00;
        short_init = 0; long_init = 0;
        tick(2);
        chk("R1 short_out", short_out, 1'b1);
        chk("R1 long_out", long_out, 1'b1);
        chk("R1 tx_out", tx_out, 1'b1);
        rst = 1'b0;

        // R2 / R3 table walk
        for (int i = 0; i < 16; i++) begin
            combine_sel = VEC[i][4:3];
            short_init  = VEC[i][2];
            long_init   = VEC[i][1];
            tick(2);
            chk("R3 idle short", short_out, ~VEC[i][2]);
            chk("R2 merge", tx_out, VEC[i][0]);
        end

        // R4 / R5 independent timing
        short_init = 1'b0; long_init = 1'b1; short_reload = 8'd3;
        tick(2);
        chk("R3 idle short", short_out, 1'b1);
        chk("R3 idle long", long_out, 1'b0);
        short_en = 1'b1;
        tick(1);
        chk("R4 start level", short_out, 1'b0);
        tick(3);
        chk("R5 before wrap", short_out, 1'b0);
        tick(1);
        chk("R5 first flip", short_out, 1'b1);
        tick(4);
        chk("R5 second flip", short_out, 1'b0);
        short_en = 1'b0;
        tick(1);
        chk("R3 disable level", short_out, 1'b1);

        // R9 start level ignored while a timer runs
        short_en = 1'b1;
        long_init = 1'b0;
        tick(3);
        chk("R9 no latch while running", long_out, 1'b0);
        short_en = 1'b0;
        tick(2);
        chk("R9 latch when idle", long_out, 1'b1);

        // R6 ping-pong
        short_reload = 8'd2; long_reload = 16'd3; submode_sel = 2'b01;
        tick(1);
        short_en = 1'b1; long_en = 1'b1;
        tick(1);
        chk("R4 pp short start", short_out, 1'b0);
        chk("R4 pp long start", long_out, 1'b0);
        tick(2);
        chk("R6 short before wrap", short_out, 1'b0);
        tick(1);
        chk("R6 short wraps first", short_out, 1'b1);
        chk("R6 long waits", long_out, 1'b0);
        tick(3);
        chk("R6 short stopped", short_out, 1'b1);
        chk("R6 long before wrap", long_out, 0);
        tick(1);
        chk("R6 long wraps", long_out, 1'b1);
        tick(3);
        chk("R6 short second turn", short_out, 1'b0);
        chk("R6 long held", long_out, 1'b1);

        // R7 back to independent
        submode_sel = 2'b00;
        tick(3);
        chk("R7 short runs", short_out, 1'b1);
        chk("R7 long not yet", long_out, 1'b1);
        tick(1);
        chk("R7 long runs together", long_out, 1'b0);

        // R8 forcing
        combine_sel = 2'b01;
        submode_sel = 2'b10;
        #1;
        chk("R8 force low", long_out, 1'b0);
        submode_sel = 2'b11;
        #1;
        chk("R8 force high", long_out, 1'b1);
        chk("R2 OR with forced high", tx_out, 1'b1);
        tick(3);
        chk("R8 force held", long_out, 1'b1);

        // R1 reset while running
        submode_sel = 2'b00;
        rst = 1'b1;
        tick(1);
        chk("R1 reset mid-run short", short_out, 1'b1);
        chk("R1 reset mid-run long", long_out, 1'b1);
        rst = 1'b0;

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule